// File: doc/BRIEF.md
# Synchronous Clocked Serial Shifter

This block moves a word of 8 or 16 bits in and out over a three-wire synchronous link: a serial clock, a data output and a data input. Bits leave least significant first. Each arriving bit enters at the top of the shift chain and moves down toward bit 0. After a full word the data registers hold the received word, and the word that was sent has been shifted out of them. In 16-bit mode a high byte register is chained above the low byte register. Serial input enters the high byte, and serial output still leaves from bit 0 of the low byte.

The serial clock has two possible sources. The first is an on-block divider that offers eight rates derived from the system clock. In that case the clock pin is driven out and sits high when idle. The second is an external clock brought in on the same pin, which is then an input. A continuous mode keeps the divided clock running on the pin even when no transfer is active. The host loads the byte registers while the unit is idle and issues a start pulse. It then watches the busy and done flags. With an external clock, extra clock activity after a word has completed and before the next start raises a sticky overrun flag.

Top module: `sser_shifter`

## Requirements
- R1: After reset, busy, done and overrun are 0, and with the internal clock selected the clock pin reads 1.
- R2: In 8-bit mode (cfg_wide=0), one start shifts out data_lo bit 0 first. The word received over 8 rising edges, first bit first, ends up in data_lo with the first received bit at bit 0.
- R3: In 16-bit mode (cfg_wide=1), 16 bits leave in the order data_lo bit 0..7 and then data_hi bit 0..7. The 16 received bits end in {data_hi, data_lo}, with the first at data_lo bit 0.
- R4: sdo changes only on a falling serial clock edge and holds across the following rising edge. sdi is sampled on the rising edge.
- R5: With the internal clock, cfg_rate codes 0 to 7 give a serial clock period of 2, 4, 8, 16, 32, 64, 256 and 1024 system clocks.
- R6: When cfg_ext_clk=0, sck_oe is 1 and sck_o stays high while idle outside continuous mode. When cfg_ext_clk=1, sck_oe is 0.
- R7: cfg_clk_mode=2'b10 with the internal clock keeps sck_o toggling at the selected rate while idle. A transfer started in this mode begins at the next falling edge.
- R8: With cfg_ext_clk=1, the unit shifts on edges of sck_i (which must be slower than system clock / 4). Both sck_i and sdi pass through a two-flop synchronizer.
- R9: busy rises on the cycle after an accepted start and done clears at the same time. busy falls and done rises together after the last rising-edge sample.
- R10: overrun sets only with the external clock, on a falling sck_i edge while idle with done set. It stays set until an ovr_clr pulse, and it never sets with the internal clock.
- R11: While busy, start pulses and writes to either data register are ignored. The transfer completes with the correct bit count and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_ext_clk | input | 1 | 1 selects the external serial clock |
| cfg_rate | input | 3 | Internal divider select |
| cfg_clk_mode | input | 2 | 2'b10 selects continuous clock output |
| cfg_wide | input | 1 | 1 selects 16-bit words |
| wr_lo | input | 1 | Write strobe for the low data byte |
| wr_hi | input | 1 | Write strobe for the high data byte |
| wdata | input | 8 | Write data |
| start | input | 1 | Start pulse |
| ovr_clr | input | 1 | Clears the overrun flag |
| data_lo | output | 8 | Low data byte |
| data_hi | output | 8 | High data byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer completed |
| overrun | output | 1 | Sticky overrun flag |
| sck_o | output | 1 | Serial clock output |
| sck_oe | output | 1 | Serial clock output enable |
| sck_i | input | 1 | Serial clock input |
| sdo | output | 1 | Serial data output |
| sdi | input | 1 | Serial data input |

## Verification
The bench drives transfers with both clock sources and both word lengths, and it checks the received word and the bit stream that was sent. A chain that shifts the wrong way, or that feeds the high byte from the wrong end, would scramble bit order. In continuous mode a transfer can be started while the clock is low. A design that counted the first rising edge before any falling edge would lose a bit. A stray start and a write to data_lo are injected during a shift; a design that obeyed them would restart the count or corrupt the word. The bench also measures the periods of the slowest and fastest divider codes, and it toggles the external clock after completion to raise overrun, proving that the flag sets only in that window and holds until cleared.

// File: rtl/sser_pkg.sv
package sser_pkg;
    localparam int BYTE_W   = 8;
    localparam int HALF_W   = 10;
    localparam int RATE_W   = 3;
    localparam logic [1:0] MODE_FREE = 2'b10;

    function automatic logic [HALF_W-1:0] half_period(input logic [RATE_W-1:0] r);
        case (r)
            3'd0:    half_period = 10'd1;
            3'd1:    half_period = 10'd2;
            3'd2:    half_period = 10'd4;
            3'd3:    half_period = 10'd8;
            3'd4:    half_period = 10'd16;
            3'd5:    half_period = 10'd32;
            3'd6:    half_period = 10'd128;
            default: half_period = 10'd512;
        endcase
    endfunction
endpackage

// File: rtl/sser_sync.sv
module sser_sync #(
    parameter int           W   = 1,
    parameter logic [W-1:0] RST = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] s1_q, s1_d, s2_q, s2_d;

    always_comb begin
        s1_d = din;
        s2_d = s1_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= RST;
            s2_q <= RST;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign dout = s2_q;
endmodule

// File: rtl/sser_clkgen.sv
module sser_clkgen
    import sser_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic [RATE_W-1:0] rate,
    output logic              sclk,
    output logic              rise_ev,
    output logic              fall_ev
);
    typedef struct packed {
        logic [HALF_W-1:0] cnt;
        logic              sclk;
    } gen_t;

    gen_t g_d, g_q;
    logic [HALF_W-1:0] half;
    logic              wrap;

    always_comb begin
        half = half_period(rate);
        wrap = !hold && (g_q.cnt >= half - 1'b1);
        g_d  = g_q;
        if (hold) begin
            g_d.cnt  = '0;
            g_d.sclk = 1'b1;
        end else if (wrap) begin
            g_d.cnt  = '0;
            g_d.sclk = ~g_q.sclk;
        end else begin
            g_d.cnt  = g_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q.cnt  <= '0;
            g_q.sclk <= 1'b1;
        end else begin
            g_q <= g_d;
        end
    end

    assign sclk    = g_q.sclk;
    assign rise_ev = wrap && !g_q.sclk;
    assign fall_ev = wrap &&  g_q.sclk;

    AST_HOLD_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> sclk); // R6
    AST_EDGE_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        fall_ev |=> !sclk); // R4
endmodule

// File: rtl/sser_shifter.sv
module sser_shifter
    import sser_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_ext_clk,
    input  logic [RATE_W-1:0] cfg_rate,
    input  logic [1:0]        cfg_clk_mode,
    input  logic              cfg_wide,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              start,
    input  logic              ovr_clr,
    output logic [BYTE_W-1:0] data_lo,
    output logic [BYTE_W-1:0] data_hi,
    output logic              busy,
    output logic              done,
    output logic              overrun,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              sck_i,
    output logic              sdo,
    input  logic              sdi
);
    localparam int BCNT_W = $clog2(2 * BYTE_W);
    localparam logic [BCNT_W-1:0] LAST_NARROW = BCNT_W'(BYTE_W - 1);
    localparam logic [BCNT_W-1:0] LAST_WIDE   = BCNT_W'(2 * BYTE_W - 1);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic              ovr;
        logic              seen_fall;
        logic              sck_prev;
        logic              sdo;
        logic [BCNT_W-1:0] bitcnt;
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] hi;
    } st_t;

    st_t st_d, st_q;

    logic [1:0] ext_sync;
    logic       gen_hold, gen_sclk, gen_rise, gen_fall;
    logic       ext_rise, ext_fall, ev_rise, ev_fall, din;
    logic [BCNT_W-1:0] last_bit;

    sser_sync #(.W(2), .RST(2'b11)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({sck_i, sdi}),
        .dout  (ext_sync)
    );

    assign gen_hold = cfg_ext_clk || (!st_q.busy && cfg_clk_mode != MODE_FREE);

    sser_clkgen u_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (gen_hold),
        .rate    (cfg_rate),
        .sclk    (gen_sclk),
        .rise_ev (gen_rise),
        .fall_ev (gen_fall)
    );

    always_comb begin
        ext_rise = ext_sync[1] && !st_q.sck_prev;
        ext_fall = !ext_sync[1] && st_q.sck_prev;
        ev_rise  = cfg_ext_clk ? ext_rise : gen_rise;
        ev_fall  = cfg_ext_clk ? ext_fall : gen_fall;
        din      = cfg_ext_clk ? ext_sync[0] : sdi;
        last_bit = cfg_wide ? LAST_WIDE : LAST_NARROW;

        st_d          = st_q;
        st_d.sck_prev = ext_sync[1];

        if (!st_q.busy) begin
            if (wr_lo) st_d.lo = wdata;
            if (wr_hi) st_d.hi = wdata;
        end

        if (ovr_clr) st_d.ovr = 1'b0;

        if (start && !st_q.busy) begin
            st_d.busy      = 1'b1;
            st_d.done      = 1'b0;
            st_d.seen_fall = 1'b0;
            st_d.bitcnt    = '0;
        end else if (st_q.busy) begin
            if (ev_fall) begin
                st_d.sdo       = st_q.lo[0];
                st_d.seen_fall = 1'b1;
            end
            if (ev_rise && st_q.seen_fall) begin
                if (cfg_wide) begin
                    st_d.hi = {din, st_q.hi[BYTE_W-1:1]};
                    st_d.lo = {st_q.hi[0], st_q.lo[BYTE_W-1:1]};
                end else begin
                    st_d.lo = {din, st_q.lo[BYTE_W-1:1]};
                end
                st_d.bitcnt = st_q.bitcnt + 1'b1;
                if (st_q.bitcnt == last_bit) begin
                    st_d.busy = 1'b0;
                    st_d.done = 1'b1;
                end
            end
        end

        if (cfg_ext_clk && !st_q.busy && st_q.done && ext_fall)
            st_d.ovr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.busy      <= 1'b0;
            st_q.done      <= 1'b0;
            st_q.ovr       <= 1'b0;
            st_q.seen_fall <= 1'b0;
            st_q.sck_prev  <= 1'b1;
            st_q.sdo       <= 1'b1;
            st_q.bitcnt    <= '0;
            st_q.lo        <= '0;
            st_q.hi        <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_lo = st_q.lo;
    assign data_hi = st_q.hi;
    assign busy    = st_q.busy;
    assign done    = st_q.done;
    assign overrun = st_q.ovr;
    assign sdo     = st_q.sdo;
    assign sck_o   = gen_sclk;
    assign sck_oe  = !cfg_ext_clk;

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R9
    AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done)); // R9
    AST_SDO_HOLDS_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rise |=> $stable(sdo)); // R4
    AST_OVR_EXT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(cfg_ext_clk)); // R10
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_clr) |=> overrun); // R10
    AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !ev_rise) |=> busy); // R11
endmodule

// File: tb/sser_shifter_bench.sv
module sser_shifter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_ext_clk = 1'b0;
    logic [2:0] cfg_rate = 3'd0;
    logic [1:0] cfg_clk_mode = 2'b00;
    logic       cfg_wide = 1'b0;
    logic       wr_lo = 1'b0, wr_hi = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       start = 1'b0, ovr_clr = 1'b0;
    logic [7:0] data_lo, data_hi;
    logic       busy, done, overrun, sck_o, sck_oe, sdo;
    logic       sck_i = 1'b1, sdi = 1'b0;

    int checks = 0;
    int errors = 0;
    logic [15:0] cap_word;
    logic [32:0] exp_q[$];

    always #10 clk = ~clk;

    sser_shifter u_sser_shifter (
        .clk(clk), .rst_n(rst_n), .cfg_ext_clk(cfg_ext_clk), .cfg_rate(cfg_rate),
        .cfg_clk_mode(cfg_clk_mode), .cfg_wide(cfg_wide), .wr_lo(wr_lo), .wr_hi(wr_hi),
        .wdata(wdata), .start(start), .ovr_clr(ovr_clr), .data_lo(data_lo),
        .data_hi(data_hi), .busy(busy), .done(done), .overrun(overrun), .sck_o(sck_o),
        .sck_oe(sck_oe), .sck_i(sck_i), .sdo(sdo), .sdi(sdi)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops an expected item on each completed word
    initial begin
        logic done_p;
        logic [32:0] it;
        done_p = 1'b0;
        forever begin
            @(negedge clk);
            if (done && !done_p) begin
                repeat (2) @(negedge clk);
                if (exp_q.size() == 0) begin
                    chk(0, "R9 unexpected done", 1, 0);
                end else begin
                    it = exp_q.pop_front();
                    if (it[32]) begin
                        chk({data_hi, data_lo} == it[15:0], "R3 rx word", {data_hi, data_lo}, it[15:0]);
                        chk(cap_word == it[31:16], "R3 tx order", cap_word, it[31:16]);
                    end else begin
                        chk(data_lo == it[7:0], "R2 rx byte", data_lo, it[7:0]);
                        chk(cap_word[7:0] == it[23:16], "R2 tx order", cap_word[7:0], it[23:16]);
                    end
                end
            end
            done_p = done;
        end
    end

    task automatic xfer(input bit wide, input logic [15:0] tx, input logic [15:0] rx,
                        input bit disturb);
        int nb;
        nb = wide ? 16 : 8;
        cfg_wide = wide;
        cap_word = '0;
        @(negedge clk); wr_lo = 1'b1; wdata = tx[7:0];
        @(negedge clk); wr_lo = 1'b0; wr_hi = 1'b1; wdata = tx[15:8];
        @(negedge clk); wr_hi = 1'b0;
        exp_q.push_back({wide, tx, rx});
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy && !done, "R9 start sets busy", {busy, done}, 2'b10);
        if (cfg_ext_clk) begin
            repeat (2) @(negedge clk);
            for (int i = 0; i < nb; i++) begin
                sck_i = 1'b0; sdi = rx[i];
                repeat (8) @(negedge clk);
                cap_word[i] = sdo;
                sck_i = 1'b1;
                repeat (8) @(negedge clk);
            end
        end else begin
            while (sck_o !== 1'b1) @(negedge clk);
            for (int i = 0; i < nb; i++) begin
                while (sck_o !== 1'b0) @(negedge clk);
                sdi = rx[i];
                if (disturb && i == 3) begin
                    wr_lo = 1'b1; wdata = 8'hFF; start = 1'b1;
                    @(negedge clk);
                    wr_lo = 1'b0; start = 1'b0;
                    chk(busy == 1'b1, "R11 start ignored while busy", busy, 1);
                end
                while (sck_o !== 1'b1) @(negedge clk);
                cap_word[i] = sdo;
            end
        end
        while (!done) @(negedge clk);
        chk(!busy, "R9 busy drops at done", busy, 0);
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_rise();
        while (sck_o !== 1'b0) @(negedge clk);
        while (sck_o !== 1'b1) @(negedge clk);
    endtask

    task automatic measure(input logic [2:0] r, input int exp);
        int n;
        cfg_rate = r;
        wait_rise();
        wait_rise();
        n = 0;
        while (sck_o !== 1'b0) begin @(negedge clk); n++; end
        while (sck_o !== 1'b1) begin @(negedge clk); n++; end
        chk(n == exp, "R5 clock period", n, exp);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int tg;
        logic prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !overrun, "R1 reset flags", {busy, done, overrun}, 0);
        chk(sck_o == 1'b1, "R1 idle clock high", sck_o, 1);

        tg = 0; prev = sck_o;
        repeat (12) begin @(negedge clk); if (sck_o != prev) tg++; prev = sck_o; end
        chk(tg == 0 && sck_o == 1'b1, "R6 idle no toggles", tg, 0);
        chk(sck_oe == 1'b1, "R6 oe internal", sck_oe, 1);
        cfg_ext_clk = 1'b1; @(negedge clk);
        chk(sck_oe == 1'b0, "R6 oe external", sck_oe, 0);
        cfg_ext_clk = 1'b0;

        cfg_rate = 3'd0;
        xfer(1'b0, 16'h00A5, 16'h003C, 1'b0);          // R2
        xfer(1'b0, 16'h0001, 16'h0080, 1'b0);          // R2 edge bits
        cfg_rate = 3'd1;
        xfer(1'b1, 16'h1234, 16'hBEEF, 1'b0);          // R3
        chk(overrun == 1'b0, "R10 no overrun internal", overrun, 0);

        cfg_clk_mode = 2'b10;
        measure(3'd0, 2);
        measure(3'd3, 16);
        measure(3'd7, 1024);
        cfg_rate = 3'd0;
        wait_rise();
        tg = 0; prev = sck_o;
        repeat (10) begin @(negedge clk); if (sck_o != prev) tg++; prev = sck_o; end
        chk(tg == 10, "R7 free-run toggles", tg, 10);
        cfg_rate = 3'd1;
        xfer(1'b1, 16'hC3A1, 16'h5A0F, 1'b0);          // R7 transfer in continuous mode
        cfg_clk_mode = 2'b00;

        cfg_rate = 3'd2;
        xfer(1'b0, 16'h0096, 16'h00E1, 1'b1);          // R11 disturbed transfer

        cfg_ext_clk = 1'b1;
        xfer(1'b0, 16'h004D, 16'h00B2, 1'b0);          // R8
        xfer(1'b1, 16'h8001, 16'h7E18, 1'b0);          // R8 wide
        chk(overrun == 1'b0, "R10 clear before extra edge", overrun, 0);
        sck_i = 1'b0; repeat (6) @(negedge clk);
        sck_i = 1'b1; repeat (6) @(negedge clk);
        chk(overrun == 1'b1, "R10 overrun set", overrun, 1);
        repeat (10) @(negedge clk);
        chk(overrun == 1'b1, "R10 overrun sticky", overrun, 1);
        ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0; @(negedge clk);
        chk(overrun == 1'b0, "R10 overrun cleared", overrun, 0);
        cfg_ext_clk = 1'b0;

        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R9 all words completed", exp_q.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule